// File: doc/BRIEF.md
# PRBS Pattern Checker with Self-Synchronization

This block checks parallel words from a loopback receive path against one of four pseudo-random binary sequences. It needs no shared seed or start marker. In the first stage it takes a received word as the state of a local shift register. It then predicts the words that follow and waits for a run of error-free words before it reports lock. Once locked, the local register runs free. Every received word that differs from the prediction adds one to a saturating error counter. A burst of mismatches inside a short window tells the block it has lost the stream, and it goes back to hunting.

Each word carries `W` bits, with the bit sent first in bit `W-1`. A word is taken only when `rx_valid_i` is high. The 3-bit `mode_i` input selects the sequence. Two clock-style test patterns (a toggling pattern and a slow square wave) can appear on the line, but they cannot be checked. In those modes the block stays unlocked and counts nothing. `err_clr_i` sets the counter back to zero.

Top module: `prbs_checker`

## Requirements
- R1: `mode_i` encodings 0, 1, 2 and 3 select the sequences x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. Encoding 0 is the PRBS7 pattern. In each sequence, bit n equals bit n-N XOR bit n-M, and the bits are sent in order from word bit W-1 down to bit 0.
- R2: In a selectable mode, the first accepted word seeds the predictor. `sync_o` rises on the clock edge that accepts the 8th consecutive following word that matches the prediction, and not before.
- R3: A word whose lowest N bits (N = the order of the selected sequence) are all zero is never taken as a seed, so an all-zero stream never brings `sync_o` high.
- R4: While `sync_o` is high, each accepted word that differs from the prediction in any bit raises `err_cnt_o` by exactly one, one clock after the word is accepted.
- R5: While locked, `sync_o` falls after a mismatching word when at least 3 of the 15 words accepted before it also mismatched. Three mismatches within 16 words do not drop lock. Mismatches that cause the drop are still counted.
- R6: While `sync_o` is low, mismatching words do not change `err_cnt_o`.
- R7: `err_clr_i` high sets `err_cnt_o` to zero on the next clock. Clearing wins over an increment in the same cycle.
- R8: `err_cnt_o` is CNT_W bits wide (32 by default) and stays at all ones instead of wrapping.
- R9: `mode_i` values 4 (toggling pattern), 5 (slow square wave), 6 and 7 keep `sync_o` low and leave `err_cnt_o` unchanged, whatever data arrives.
- R10: A change of `mode_i` between two clocks forces `sync_o` low after the second clock, and acquisition restarts.
- R11: Cycles with `rx_valid_i` low change neither `sync_o` nor `err_cnt_o`, and they do not advance the predictor.
- R12: After reset, `sync_o` is 0 and `err_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Pattern select (0-3 sequences, 4-7 not checkable) |
| rx_valid_i | input | 1 | Received word is present this cycle |
| rx_data_i | input | W | Received word, bit W-1 first in time |
| err_clr_i | input | 1 | Zero the error counter |
| sync_o | output | 1 | Pattern lock status |
| err_cnt_o | output | CNT_W | Saturating count of mismatching words |

## Verification
A clear request and a counted mismatch can land on the same clock. The bench provokes this by driving a corrupted word while the block is locked, with `err_clr_i` high in that same cycle. The result is judged correct only if the counter reads zero afterwards, and a later lone mismatch then reads one. The bench also provokes a drop of lock and a counted error in the same cycle, with the fourth mismatch of a burst, and expects both effects.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int STATE_W = 31;
  localparam int NUM_ORD = 4;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } sync_st_e;

  function automatic int ord_len(input int g);
    case (g)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int ord_tap(input int g);
    case (g)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/prbs_lane.sv
// One word of a Fibonacci sequence, unrolled from a given state.
// State bit 0 holds the most recent bit.
module prbs_lane #(
  parameter int W   = 32,
  parameter int SW  = 31,
  parameter int ORD = 7,
  parameter int TAP = 6
) (
  input  logic [SW-1:0] seed_i,
  output logic [W-1:0]  word_o
);

  logic [SW-1:0] sh;
  logic          nb;
  logic [W-1:0]  acc;

  always_comb begin
    sh  = seed_i;
    nb  = 1'b0;
    acc = '0;
    for (int i = W - 1; i >= 0; i--) begin
      nb     = sh[ORD-1] ^ sh[TAP-1];
      acc[i] = nb;
      sh     = {sh[SW-2:0], nb};
    end
  end

  assign word_o = acc;

endmodule

// File: rtl/prbs_predict.sv
module prbs_predict
  import prbs_chk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [W-1:0]       rx_i,
  input  logic [1:0]         sel_i,
  output logic [W-1:0]       pred_o,
  output logic               seed_nz_o
);

  logic [W-1:0]       lane_w [NUM_ORD];
  logic [NUM_ORD-1:0] nz;

  for (genvar g = 0; g < NUM_ORD; g++) begin : g_ord
    localparam int LEN = ord_len(g);
    localparam int TP  = ord_tap(g);

    prbs_lane #(
      .W  (W),
      .SW (STATE_W),
      .ORD(LEN),
      .TAP(TP)
    ) u_lane (
      .seed_i(state_i),
      .word_o(lane_w[g])
    );

    assign nz[g] = |rx_i[LEN-1:0];
  end

  assign pred_o    = lane_w[sel_i];
  assign seed_nz_o = nz[sel_i];

endmodule

// File: rtl/prbs_sync_fsm.sv
module prbs_sync_fsm
  import prbs_chk_pkg::*;
#(
  parameter int LOCK_GOOD = 8,
  parameter int WIN       = 16,
  parameter int WIN_BAD   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic mode_ok_i,
  input  logic mode_chg_i,
  input  logic mism_i,
  input  logic seed_nz_i,
  output logic locked_o,
  output logic load_o,
  output logic adv_o,
  output logic cnt_en_o
);

  localparam int GW = $clog2(LOCK_GOOD);
  localparam int HW = WIN - 1;
  localparam int CW = $clog2(WIN);

  sync_st_e      st_q, st_d;
  logic [GW-1:0] good_q, good_d;
  logic [HW-1:0] hist_q, hist_d;
  logic [CW-1:0] hist_ones;
  logic          take;

  assign take      = valid_i && mode_ok_i && !mode_chg_i;
  assign hist_ones = CW'($countones(hist_q));

  always_comb begin
    st_d     = st_q;
    good_d   = good_q;
    hist_d   = hist_q;
    load_o   = 1'b0;
    cnt_en_o = 1'b0;
    if (!mode_ok_i || mode_chg_i) begin
      st_d   = ST_HUNT;
      good_d = '0;
    end else if (valid_i) begin
      case (st_q)
        ST_HUNT: begin
          if (seed_nz_i) begin
            load_o = 1'b1;
            st_d   = ST_CHECK;
            good_d = '0;
          end
        end
        ST_CHECK: begin
          if (mism_i) begin
            good_d = '0;
            if (seed_nz_i) load_o = 1'b1;
            else           st_d   = ST_HUNT;
          end else if (good_q == GW'(LOCK_GOOD - 1)) begin
            st_d   = ST_LOCK;
            hist_d = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
        ST_LOCK: begin
          cnt_en_o = mism_i;
          hist_d   = {hist_q[HW-2:0], mism_i};
          if (mism_i && (hist_ones >= CW'(WIN_BAD - 1))) begin
            st_d   = ST_HUNT;
            good_d = '0;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  assign adv_o    = take && (st_q != ST_HUNT) && !load_o;
  assign locked_o = (st_q == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      hist_q <= '0;
    end else begin
      st_q   <= st_d;
      good_q <= good_d;
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/prbs_err_ctr.sv
module prbs_err_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign en = clr_i || (inc_i && (cnt_q != TOP));

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/prbs_checker.sv
module prbs_checker
  import prbs_chk_pkg::*;
#(
  parameter int W         = 32,
  parameter int CNT_W     = 32,
  parameter int LOCK_GOOD = 8,
  parameter int WIN       = 16,
  parameter int WIN_BAD   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             rx_valid_i,
  input  logic [W-1:0]     rx_data_i,
  input  logic             err_clr_i,
  output logic             sync_o,
  output logic [CNT_W-1:0] err_cnt_o
);

  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic [2:0]         mode_q;
  logic               mode_chg;
  logic               mode_ok;
  logic [STATE_W-1:0] lfsr_q, lfsr_d;
  logic               lfsr_en;
  logic [W-1:0]       pred;
  logic               seed_nz;
  logic               mism;
  logic               load;
  logic               adv;
  logic               cnt_en;
  logic               locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= 3'd0;
    else            mode_q <= mode_i;
  end

  assign mode_chg = (mode_i != mode_q);
  assign mode_ok  = !mode_i[2];

  prbs_predict #(.W(W)) u_pred (
    .state_i  (lfsr_q),
    .rx_i     (rx_data_i),
    .sel_i    (mode_i[1:0]),
    .pred_o   (pred),
    .seed_nz_o(seed_nz)
  );

  assign mism = (pred != rx_data_i);

  prbs_sync_fsm #(
    .LOCK_GOOD(LOCK_GOOD),
    .WIN      (WIN),
    .WIN_BAD  (WIN_BAD)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .valid_i   (rx_valid_i),
    .mode_ok_i (mode_ok),
    .mode_chg_i(mode_chg),
    .mism_i    (mism),
    .seed_nz_i (seed_nz),
    .locked_o  (locked),
    .load_o    (load),
    .adv_o     (adv),
    .cnt_en_o  (cnt_en)
  );

  assign lfsr_en = load || adv;

  always_comb begin
    if (load) lfsr_d = rx_data_i[STATE_W-1:0];
    else      lfsr_d = pred[STATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   lfsr_q <= '0;
    else if (lfsr_en) lfsr_q <= lfsr_d;
  end

  prbs_err_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr_i(err_clr_i),
    .inc_i(cnt_en),
    .cnt_o(err_cnt_o)
  );

  assign sync_o = locked;

endmodule

// File: rtl/prbs_checker_sva.sv
module prbs_checker_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic             rx_valid_i,
  input logic             err_clr_i,
  input logic             sync_o,
  input logic [CNT_W-1:0] err_cnt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_comb begin
    if (!rst_n) begin
      a_r12_reset_idle: assert (rst_n || (!sync_o && err_cnt_o == '0));
    end
  end

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i |=> (err_cnt_o == '0));

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr_i |=> ((err_cnt_o == $past(err_cnt_o)) ||
                    (err_cnt_o == $past(err_cnt_o) + 1'b1)));

  a_r6_hold_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_o && !err_clr_i) |=> $stable(err_cnt_o));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_o == TOP && !err_clr_i) |=> (err_cnt_o == TOP));

  a_r9_no_lock_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[2] |=> !sync_o);

  a_r10_mode_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_i) |=> !sync_o);

  a_r2_rise_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(rx_valid_i));

  a_r11_idle_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid_i && !err_clr_i) |=> $stable(err_cnt_o));

  a_r11_idle_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid_i && $stable(mode_i)) |=> $stable(sync_o));

endmodule

bind prbs_checker prbs_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .rx_valid_i(rx_valid_i),
  .err_clr_i (err_clr_i),
  .sync_o    (sync_o),
  .err_cnt_o (err_cnt_o)
);

// File: tb/sim_prbs_checker.sv
`timescale 1ns/1ps
module sim_prbs_checker;

  localparam int W      = 32;
  localparam int CNT_W  = 6;
  localparam int MAXCNT = (1 << CNT_W) - 1;
  localparam int LIMIT  = 200000;

  logic             clk;
  logic             rst_n;
  logic [2:0]       mode;
  logic             rx_valid;
  logic [W-1:0]     rx_data;
  logic             err_clr;
  logic             sync;
  logic [CNT_W-1:0] err_cnt;

  int          n_tests;
  int          n_fail;
  bit          done;
  int          ord_g;
  logic [30:0] gs;
  int          exp_err;

  prbs_checker #(.W(W), .CNT_W(CNT_W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .rx_valid_i(rx_valid),
    .rx_data_i (rx_data),
    .err_clr_i (err_clr),
    .sync_o    (sync),
    .err_cnt_o (err_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // R1: sequence definition, independent reference generator
  function automatic logic [W-1:0] ref_word(input int o, input logic [30:0] st);
    int          n;
    int          t;
    logic [30:0] s;
    logic        b;
    logic [W-1:0] r;
    n = (o == 0) ? 7 : (o == 1) ? 15 : (o == 2) ? 23 : 31;
    t = (o == 0) ? 6 : (o == 1) ? 14 : (o == 2) ? 18 : 28;
    s = st;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      b    = s[n-1] ^ s[t-1];
      r[i] = b;
      s    = {s[29:0], b};
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [63:0] r;
    r = {$urandom, $urandom};
    return r[W-1:0];
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [W-1:0] d, input logic c);
    @(negedge clk);
    rx_valid = v;
    rx_data  = d;
    err_clr  = c;
    @(posedge clk);
    #2;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode     = m;
    rx_valid = 1'b0;
    err_clr  = 1'b0;
    @(posedge clk);
    #2;
  endtask

  task automatic send(input bit inj, input bit clr);
    logic [W-1:0] w;
    if ($urandom % 6 == 0) drive(1'b0, rnd_word(), 1'b0);
    w  = ref_word(ord_g, gs);
    gs = w[30:0];
    if (inj) w = w ^ (W'(1) << ($urandom % W));
    drive(1'b1, w, clr);
  endtask

  task automatic acquire(input int o);
    int n;
    n     = (o == 0) ? 7 : (o == 1) ? 15 : (o == 2) ? 23 : 31;
    ord_g = o;
    set_mode(3'd4);
    set_mode(3'(o));
    gs = 31'($urandom);
    if ((gs & 31'((64'd1 << n) - 1)) == 31'd0) gs[0] = 1'b1;
    for (int i = 0; i < 8; i++) send(1'b0, 1'b0);
    check($sformatf("R2 no sync after 7 good words, order %0d", o), sync, 0);
    send(1'b0, 1'b0);
    check($sformatf("R2/R1 sync after 8th good word, order %0d", o), sync, 1);
  endtask

  initial begin
    #(LIMIT * 20);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    n_tests  = 0;
    n_fail   = 0;
    done     = 1'b0;
    exp_err  = 0;
    ord_g    = 0;
    gs       = 31'd1;
    rst_n    = 1'b0;
    mode     = 3'd0;
    rx_valid = 1'b0;
    rx_data  = '0;
    err_clr  = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R12 sync after reset", sync, 0);
    check("R12 count after reset", err_cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;

    // R1/R2: every order locks on a clean stream
    for (int o = 0; o < 4; o++) begin
      acquire(o);
      for (int i = 0; i < 20; i++) send(1'b0, 1'b0);
      check("R1 clean stream stays locked", sync, 1);
      check("R4 clean stream no errors", err_cnt, 0);
    end

    // R4: single error while locked
    acquire(0);
    send(1'b1, 1'b0);
    exp_err++;
    check("R4 single mismatch counted", err_cnt, exp_err);
    check("R4 single mismatch keeps lock", sync, 1);
    for (int i = 0; i < 16; i++) send(1'b0, 1'b0);

    // R5: three mismatches in 16 words keep lock
    for (int i = 0; i < 11; i++) send((i % 5) == 0, 1'b0);
    exp_err += 3;
    check("R5 three in window keep lock", sync, 1);
    check("R4 three mismatches counted", err_cnt, exp_err);
    for (int i = 0; i < 20; i++) send(1'b0, 1'b0);

    // R5: four in a row drop lock, all counted
    for (int i = 0; i < 3; i++) send(1'b1, 1'b0);
    check("R5 lock held after third burst error", sync, 1);
    send(1'b1, 1'b0);
    exp_err += 4;
    check("R5 lock lost on fourth error", sync, 0);
    check("R5 burst errors counted", err_cnt, exp_err);

    // R6: errors during reacquisition not counted
    for (int i = 0; i < 4; i++) send(1'b0, 1'b0);
    send(1'b1, 1'b0);
    check("R6 unsynced mismatch not counted", err_cnt, exp_err);
    for (int i = 0; i < 30; i++) send(1'b0, 1'b0);
    check("R6 relock after acquisition error", sync, 1);
    check("R6 count unchanged after relock", err_cnt, exp_err);

    // R7: clear and mismatch in the same cycle
    send(1'b1, 1'b1);
    exp_err = 0;
    check("R7 clear wins over increment", err_cnt, 0);
    send(1'b1, 1'b0);
    exp_err = 1;
    check("R7 count resumes after clear", err_cnt, 1);
    send(1'b0, 1'b1);
    exp_err = 0;
    check("R7 plain clear", err_cnt, 0);

    // R11: invalid cycles ignored
    acquire(3);
    for (int i = 0; i < 10; i++) drive(1'b0, rnd_word(), 1'b0);
    check("R11 invalid cycles keep sync", sync, 1);
    check("R11 invalid cycles keep count", err_cnt, exp_err);
    for (int i = 0; i < 10; i++) send(1'b0, 1'b0);
    check("R11 predictor not advanced by invalid", err_cnt, exp_err);

    // R4: constrained random spaced errors
    for (int k = 0; k < 12; k++) begin
      int gap;
      gap = 16 + int'($urandom % 20);
      for (int i = 0; i < gap; i++) send(1'b0, 1'b0);
      send(1'b1, 1'b0);
      exp_err++;
    end
    check("R4 random spaced errors counted", err_cnt, exp_err);
    check("R4 random spaced errors keep lock", sync, 1);

    // R10: mode change drops lock
    acquire(1);
    set_mode(3'd2);
    check("R10 mode change drops sync", sync, 0);

    // R9: fixed patterns never lock or count
    ord_g = 0;
    set_mode(3'd4);
    for (int i = 0; i < 30; i++) drive(1'b1, {(W/2){2'b10}}, 1'b0);
    check("R9 toggling pattern no sync", sync, 0);
    set_mode(3'd5);
    for (int i = 0; i < 30; i++) send((i % 3) == 0, 1'b0);
    check("R9 square-wave mode no sync on sequence", sync, 0);
    check("R9 no counting in fixed modes", err_cnt, exp_err);

    // R3: all-zero stream never locks
    set_mode(3'd0);
    for (int i = 0; i < 20; i++) drive(1'b1, '0, 1'b0);
    check("R3 zero stream no sync", sync, 0);

    // R8: saturation
    acquire(2);
    send(1'b0, 1'b1);
    exp_err = 0;
    for (int k = 0; k < MAXCNT + 7; k++) begin
      send(1'b1, 1'b0);
      for (int i = 0; i < 7; i++) send(1'b0, 1'b0);
    end
    check("R8 counter saturates", err_cnt, MAXCNT);
    check("R8 lock kept during saturation run", sync, 1);
    send(1'b0, 1'b1);
    check("R7 clear from saturation", err_cnt, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule